// File: doc/BRIEF.md
# Serial Flash Command Front End

This block sits between a serial peripheral bus and the control core of a serial flash memory. The bus pins (select, clock, data in, write-protect, hardware reset) are sampled with the chip's own clock. The block collects an opcode and, where the command needs one, a three-byte address. It sorts each command into one of four classes and passes it to the core as a one-cycle command pulse that carries the opcode, page number and byte offset.

Reads and status reads stream bytes taken from a byte source on one, two or four output lanes. A byte is shifted out on each falling bus clock edge, and the block requests the next byte as it loads the current one. Program, erase and protection commands are issued only when the select frame closes cleanly. The write-protect pin can veto them. A special opcode arms a completion signal: while the host keeps the device selected, data line 1 flips when the core's busy flag drops. A low level on the hardware reset pin aborts the current frame. The exception is a quad read, during which that pin serves as a data line.

Top module: `sflash_spi_front`

## Requirements
- R1: While `cs_ni` is high all `io_oe_o` bits are 0 from the second clock after it is sampled high. Data and clock activity with `cs_ni` high issues no command. A frame begins only on a falling edge of `cs_ni`.
- R2: Input bits are taken on rising `sck_i` edges and output bits change on falling edges. This holds both with `sck_i` idling low (mode 0) and with it idling high (mode 3).
- R3: Opcodes arrive MSB first. Classes on `cmd_class_o`: 0 read (03h, 3Bh, 6Bh), 1 program/erase (02h, 20h, D8h), 2 protection (3Dh enable, 7Fh lockdown, FCh protection-register write), 3 status (D7h, 25h). Any other opcode is ignored for the rest of the frame.
- R4: Three address bytes follow read and program/erase opcodes, MSB first. `cmd_page_o` is address bits 23..10 and `cmd_offset_o` is bits 9..0. A read is issued right after its last address bit.
- R5: A single-lane read (03h) drives each byte MSB first on `io_o[1]` with `io_oe_o`=0010b. The next byte comes from `rd_byte_i` and is acknowledged by a one-cycle `rd_req_o` pulse.
- R6: A dual read (3Bh) drives two bits per falling edge: `io_o[1]` carries the more significant bit and `io_o[0]` the less significant one, with `io_oe_o`=0011b. A quad read (6Bh) drives four bits on `io_o[3:0]`, bit 3 the most significant, with `io_oe_o`=1111b.
- R7: A quad read while `qe_i` is 0 is discarded. No command is issued and no lane is driven.
- R8: With `wp_ni` low at frame end, program/erase and FCh are dropped. 3Dh and 7Fh are still issued.
- R9: Program/erase and protection commands are issued when `cs_ni` rises, and only if the frame holds whole bytes. Program/erase also needs all three address bytes.
- R10: `dev_rst_ni` low aborts the frame and undriven lanes return to idle. Nothing restarts until the next falling edge of `cs_ni`. During a quad read the pin is ignored.
- R11: Opcode 25h is issued as status and then holds `io_o[1]` driven at 0. The line flips when `busy_i` falls, and it stays driven until `cs_ni` rises.
- R12: Opcode D7h is issued as status after its eighth bit and then streams bytes on one lane as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, samples all bus pins |
| rst_ni | input | 1 | Asynchronous active-low core reset |
| cs_ni | input | 1 | Bus select, active low |
| sck_i | input | 1 | Bus clock |
| si_i | input | 1 | Serial data in (lane 0) |
| wp_ni | input | 1 | Write protect, active low |
| dev_rst_ni | input | 1 | Hardware reset pin, active low |
| qe_i | input | 1 | Quad lanes enabled by configuration |
| busy_i | input | 1 | Self-timed operation in progress |
| rd_byte_i | input | 8 | Next byte to be shifted out |
| rd_req_o | output | 1 | Pulse: current byte taken from `rd_byte_i` |
| io_o | output | 4 | Output values of lanes 3..0 |
| io_oe_o | output | 4 | Output enables of lanes 3..0 |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_class_o | output | 2 | Command class |
| cmd_op_o | output | 8 | Opcode |
| cmd_page_o | output | 14 | Page number |
| cmd_offset_o | output | 10 | Byte offset within page |

## Verification
The hardest case to reach is a hardware reset that lands in the middle of a frame while select stays low. After the pin is released, the rest of the frame has to stay inert. The bench pulls the reset pin low halfway through a program frame's address, releases it, clocks in the remaining address bits and then closes the frame normally. It expects no command pulse. It then repeats the pulse during a quad read, where the output enables must not move. The completion toggle needs a busy period that spans the armed state. The bench therefore raises `busy_i` before it sends 25h and drops it only after checking that the line holds still.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {CL_READ = 2'd0, CL_PROG = 2'd1, CL_PROT = 2'd2, CL_STAT = 2'd3} cls_e;
  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;

  localparam logic [7:0] OP_RD1 = 8'h03;
  localparam logic [7:0] OP_RD2 = 8'h3B;
  localparam logic [7:0] OP_RD4 = 8'h6B;
  localparam logic [7:0] OP_PGM = 8'h02;
  localparam logic [7:0] OP_ERS = 8'h20;
  localparam logic [7:0] OP_BLK = 8'hD8;
  localparam logic [7:0] OP_PEN = 8'h3D;
  localparam logic [7:0] OP_LCK = 8'h7F;
  localparam logic [7:0] OP_PRW = 8'hFC;
  localparam logic [7:0] OP_STS = 8'hD7;
  localparam logic [7:0] OP_INT = 8'h25;

  typedef struct packed {
    logic  known;
    cls_e  cls;
    lane_e lanes;
    logic  needs_addr;
    logic  wp_gated;
    logic  immediate;
  } dec_t;
endpackage

// File: rtl/sfs_pin_sync.sv
module sfs_pin_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_o <= RST_VAL;
    else         prev_o <= q_o;
endmodule

// File: rtl/sfs_op_decode.sv
module sfs_op_decode
  import sfs_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{known: 1'b0, cls: CL_READ, lanes: LN_1,
              needs_addr: 1'b0, wp_gated: 1'b0, immediate: 1'b0};
    unique case (op_i)
      OP_RD1: dec_o = '{1'b1, CL_READ, LN_1, 1'b1, 1'b0, 1'b0};
      OP_RD2: dec_o = '{1'b1, CL_READ, LN_2, 1'b1, 1'b0, 1'b0};
      OP_RD4: dec_o = '{1'b1, CL_READ, LN_4, 1'b1, 1'b0, 1'b0};
      OP_PGM, OP_ERS, OP_BLK:
              dec_o = '{1'b1, CL_PROG, LN_1, 1'b1, 1'b1, 1'b0};
      OP_PEN, OP_LCK:
              dec_o = '{1'b1, CL_PROT, LN_1, 1'b0, 1'b0, 1'b0};
      OP_PRW: dec_o = '{1'b1, CL_PROT, LN_1, 1'b0, 1'b1, 1'b0};
      OP_STS, OP_INT:
              dec_o = '{1'b1, CL_STAT, LN_1, 1'b0, 1'b0, 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/sfs_out_shift.sv
module sfs_out_shift
  import sfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       step_i,
  input  lane_e      lanes_i,
  input  logic [7:0] byte_i,
  output logic [3:0] nib_o,
  output logic       load_o
);
  logic [7:0] sh_q;
  logic [3:0] left_q;
  logic [3:0] step_w;

  always_comb begin
    unique case (lanes_i)
      LN_2:    step_w = 4'd2;
      LN_4:    step_w = 4'd4;
      default: step_w = 4'd1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; left_q <= '0; nib_o <= '0; load_o <= 1'b0;
    end else if (clr_i) begin
      sh_q <= '0; left_q <= '0; nib_o <= '0; load_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (step_i) begin
        if (left_q == 4'd0) begin
          nib_o  <= byte_i[7:4];
          sh_q   <= byte_i << step_w;
          left_q <= 4'd8 - step_w;
          load_o <= 1'b1;
        end else begin
          nib_o  <= sh_q[7:4];
          sh_q   <= sh_q << step_w;
          left_q <= left_q - step_w;
        end
      end
    end
  end
endmodule

// File: rtl/sflash_spi_front.sv
module sflash_spi_front
  import sfs_pkg::*;
#(
  parameter int PAGE_W      = 14,
  parameter int OFF_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              wp_ni,
  input  logic              dev_rst_ni,
  input  logic              qe_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_byte_i,
  output logic              rd_req_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_class_o,
  output logic [7:0]        cmd_op_o,
  output logic [PAGE_W-1:0] cmd_page_o,
  output logic [OFF_W-1:0]  cmd_offset_o
);
  localparam int ADDR_W     = PAGE_W + OFF_W;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int BC_W       = $clog2(ADDR_BYTES + 2);
  localparam logic [BC_W-1:0] BC_ADDR_DONE = BC_W'(ADDR_BYTES + 1);
  localparam logic [BC_W-1:0] BC_LAST_ADDR = BC_W'(ADDR_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_TX, S_ARM, S_DROP} st_e;

  // pin order: cs, sck, si, wp, dev reset
  logic [4:0] pin_s, pin_p;
  logic cs_s, cs_p, sck_s, sck_p, si_s, wp_s, drst_s;

  sfs_pin_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, si_i, wp_ni, dev_rst_ni}),
    .q_o    (pin_s),
    .prev_o (pin_p)
  );

  assign {cs_s, sck_s, si_s, wp_s, drst_s} = pin_s;
  assign cs_p  = pin_p[4];
  assign sck_p = pin_p[3];

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = ~cs_s & cs_p;
  assign cs_rise  = cs_s & ~cs_p;
  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;

  st_e               state_q;
  logic [ADDR_W-1:0] sr_q, addr_q;
  logic [2:0]        bit_q;
  logic [BC_W-1:0]   byte_q;
  logic [7:0]        op_q;
  dec_t              dec_q, dec_nx;
  lane_e             lanes_q;
  logic              tog_q, busy_q;

  logic [ADDR_W-1:0] sr_nx;
  logic [7:0]        op_nx;
  assign sr_nx = {sr_q[ADDR_W-2:0], si_s};
  assign op_nx = {sr_q[6:0], si_s};

  sfs_op_decode u_dec (.op_i(op_nx), .dec_o(dec_nx));

  logic quad_live, abort;
  assign quad_live = (state_q == S_TX) && (lanes_q == LN_4);
  assign abort     = ~drst_s & ~quad_live;

  logic defer_ok;
  assign defer_ok = (bit_q == 3'd0) && (byte_q != '0) && dec_q.known &&
                    (dec_q.cls inside {CL_PROG, CL_PROT}) &&
                    (!dec_q.needs_addr || byte_q == BC_ADDR_DONE) &&
                    (!dec_q.wp_gated || wp_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      sr_q         <= '0;
      addr_q       <= '0;
      bit_q        <= '0;
      byte_q       <= '0;
      op_q         <= '0;
      dec_q        <= '0;
      lanes_q      <= LN_1;
      tog_q        <= 1'b0;
      busy_q       <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_class_o  <= '0;
      cmd_op_o     <= '0;
      cmd_page_o   <= '0;
      cmd_offset_o <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      busy_q      <= busy_i;
      if (abort) begin
        state_q <= S_IDLE;
        tog_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE: if (cs_fall) begin
            state_q <= S_RX;
            bit_q   <= '0;
            byte_q  <= '0;
          end
          S_RX: begin
            if (cs_rise) begin
              state_q <= S_IDLE;
              if (defer_ok) begin
                cmd_valid_o  <= 1'b1;
                cmd_class_o  <= dec_q.cls;
                cmd_op_o     <= op_q;
                cmd_page_o   <= addr_q[ADDR_W-1:OFF_W];
                cmd_offset_o <= addr_q[OFF_W-1:0];
              end
            end else if (sck_rise) begin
              sr_q  <= sr_nx;
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                if (byte_q != BC_ADDR_DONE) byte_q <= byte_q + 1'b1;
                if (byte_q == '0) begin
                  op_q  <= op_nx;
                  dec_q <= dec_nx;
                  if (!dec_nx.known) begin
                    state_q <= S_DROP;
                  end else if (dec_nx.immediate) begin
                    cmd_valid_o  <= 1'b1;
                    cmd_class_o  <= dec_nx.cls;
                    cmd_op_o     <= op_nx;
                    cmd_page_o   <= '0;
                    cmd_offset_o <= '0;
                    lanes_q      <= LN_1;
                    tog_q        <= 1'b0;
                    state_q      <= (op_nx == OP_INT) ? S_ARM : S_TX;
                  end
                end else if (byte_q == BC_LAST_ADDR) begin
                  addr_q <= sr_nx;
                  if (dec_q.cls == CL_READ) begin
                    if (dec_q.lanes == LN_4 && !qe_i) begin
                      state_q <= S_DROP;
                    end else begin
                      cmd_valid_o  <= 1'b1;
                      cmd_class_o  <= CL_READ;
                      cmd_op_o     <= op_q;
                      cmd_page_o   <= sr_nx[ADDR_W-1:OFF_W];
                      cmd_offset_o <= sr_nx[OFF_W-1:0];
                      lanes_q      <= dec_q.lanes;
                      state_q      <= S_TX;
                    end
                  end
                end
              end
            end
          end
          S_TX:   if (cs_rise) state_q <= S_IDLE;
          S_ARM: begin
            if (cs_rise) state_q <= S_IDLE;
            else if (busy_q && !busy_i) tog_q <= ~tog_q;
          end
          S_DROP: if (cs_rise) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  logic [3:0] nib;

  sfs_out_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != S_TX),
    .step_i  (sck_fall),
    .lanes_i (lanes_q),
    .byte_i  (rd_byte_i),
    .nib_o   (nib),
    .load_o  (rd_req_o)
  );

  always_comb begin
    io_o    = '0;
    io_oe_o = '0;
    unique case (state_q)
      S_TX: unique case (lanes_q)
        LN_2: begin io_oe_o = 4'b0011; io_o = {2'b00, nib[3], nib[2]}; end
        LN_4: begin io_oe_o = 4'b1111; io_o = nib; end
        default: begin io_oe_o = 4'b0010; io_o = {2'b00, nib[3], 1'b0}; end
      endcase
      S_ARM: begin io_oe_o = 4'b0010; io_o = {2'b00, tog_q, 1'b0}; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sflash_spi_front_chk.sv
module sflash_spi_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       wp_s,
  input logic       qe_i,
  input logic [3:0] io_oe_o,
  input logic       rd_req_o,
  input logic       cmd_valid_o,
  input logic [1:0] cmd_class_o
);
  a_r1_hiz_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (io_oe_o == 4'b0000));

  a_r8_prog_needs_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_class_o == 2'd1) |-> $past(wp_s));

  a_r7_quad_needs_qe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_oe_o[3]) |-> $past(qe_i));

  a_r5_req_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (io_oe_o != 4'b0000));

  a_r3_cmd_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  always_comb begin
    if (rst_ni) begin
      a_r6_oe_legal: assert (io_oe_o inside {4'b0000, 4'b0010, 4'b0011, 4'b1111});
    end
  end
endmodule

bind sflash_spi_front sflash_spi_front_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s        (cs_s),
  .wp_s        (wp_s),
  .qe_i        (qe_i),
  .io_oe_o     (io_oe_o),
  .rd_req_o    (rd_req_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_class_o (cmd_class_o)
);

// File: tb/sflash_spi_front_tb_top.sv
module sflash_spi_front_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, si_i = 1'b0, wp_ni = 1'b1;
  logic dev_rst_ni = 1'b1, qe_i = 1'b0, busy_i = 1'b0;
  logic [7:0] rd_byte_i;
  logic rd_req_o, cmd_valid_o;
  logic [3:0] io_o, io_oe_o;
  logic [1:0] cmd_class_o;
  logic [7:0] cmd_op_o;
  logic [13:0] cmd_page_o;
  logic [9:0] cmd_offset_o;

  always #2 clk_i = ~clk_i;

  sflash_spi_front dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .si_i(si_i),
    .wp_ni(wp_ni), .dev_rst_ni(dev_rst_ni), .qe_i(qe_i), .busy_i(busy_i),
    .rd_byte_i(rd_byte_i), .rd_req_o(rd_req_o), .io_o(io_o), .io_oe_o(io_oe_o),
    .cmd_valid_o(cmd_valid_o), .cmd_class_o(cmd_class_o), .cmd_op_o(cmd_op_o),
    .cmd_page_o(cmd_page_o), .cmd_offset_o(cmd_offset_o)
  );

  localparam logic [23:0] ADDR = 24'hB74E95;

  int n_chk = 0, n_err = 0, n_cmd = 0;
  logic [1:0] last_cls;
  logic [7:0] last_op;
  logic [13:0] last_page;
  logic [9:0] last_off;
  logic [7:0] src = 8'h00;
  assign rd_byte_i = src;

  always @(posedge clk_i) begin
    if (cmd_valid_o) begin
      n_cmd <= n_cmd + 1;
      last_cls <= cmd_class_o; last_op <= cmd_op_o;
      last_page <= cmd_page_o; last_off <= cmd_offset_o;
    end
    if (rd_req_o) src <= src + 8'd1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk_i);
  endtask

  task automatic bit_io(input logic b, output logic [3:0] io, output logic [3:0] oe);
    sck_i = 1'b0; si_i = b;
    half();
    io = io_o; oe = io_oe_o;
    sck_i = 1'b1;
    half();
  endtask

  task automatic frame_start(input logic m3);
    sck_i = m3; half();
    cs_ni = 1'b0; half();
  endtask

  task automatic frame_end(input logic m3);
    if (!m3) sck_i = 1'b0;
    half();
    cs_ni = 1'b1;
    half(); half();
  endtask

  task automatic send_bits(input logic [39:0] v, input int n);
    logic [3:0] io, oe;
    for (int i = 0; i < n; i++) bit_io(v[39-i], io, oe);
  endtask

  task automatic rd_test(input logic [7:0] op, input logic m3, input int lanes,
                         input logic [7:0] base, input logic [3:0] exp_oe, input string req);
    logic [3:0] io, oe;
    logic [7:0] got;
    int c0;
    c0 = n_cmd;
    src = base;
    frame_start(m3);
    send_bits({op, ADDR, 8'h00}, 32);
    half();
    chk(n_cmd == c0 + 1 && last_cls == 2'd0 && last_op == op, "R4 read issued", last_op, op);
    chk(last_page == ADDR[23:10] && last_off == ADDR[9:0], "R4 page/offset", {last_page, last_off}, ADDR);
    for (int b = 0; b < 2; b++) begin
      got = '0;
      for (int s = 0; s < 8 / lanes; s++) begin
        bit_io(1'b0, io, oe);
        chk(oe == exp_oe, {req, " oe"}, oe, exp_oe);
        if (lanes == 1) got = {got[6:0], io[1]};
        else if (lanes == 2) got = {got[5:0], io[1], io[0]};
        else got = {got[3:0], io};
      end
      chk(got == base + 8'(b), {req, " R2 data byte"}, got, base + 8'(b));
    end
    frame_end(m3);
    chk(io_oe_o == 4'b0000, "R1 hiz after read", io_oe_o, 0);
  endtask

  // {op[17:10], wp[9], nbits[8:3], issue[2], class[1:0]}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {8'h02, 1'b1, 6'd32, 1'b1, 2'd1},
    {8'h02, 1'b0, 6'd32, 1'b0, 2'd1},
    {8'h20, 1'b1, 6'd32, 1'b1, 2'd1},
    {8'hD8, 1'b0, 6'd32, 1'b0, 2'd1},
    {8'h3D, 1'b0, 6'd8,  1'b1, 2'd2},
    {8'h7F, 1'b0, 6'd8,  1'b1, 2'd2},
    {8'hFC, 1'b0, 6'd8,  1'b0, 2'd2},
    {8'hFC, 1'b1, 6'd8,  1'b1, 2'd2},
    {8'h02, 1'b1, 6'd20, 1'b0, 2'd1},
    {8'h02, 1'b1, 6'd35, 1'b0, 2'd1},
    {8'h3D, 1'b1, 6'd5,  1'b0, 2'd2},
    {8'h55, 1'b1, 6'd32, 1'b0, 2'd0},
    {8'hD8, 1'b1, 6'd40, 1'b1, 2'd1}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [3:0] io, oe;
    int c0;
    repeat (3) @(negedge clk_i);
    chk(io_oe_o == 4'b0000 && cmd_valid_o == 1'b0 && rd_req_o == 1'b0, "R1 reset state", io_oe_o, 0);
    rst_ni = 1'b1;
    half();

    // R3 R8 R9: frame table, alternating bus modes
    for (int i = 0; i < NV; i++) begin
      logic [17:0] e;
      logic m3;
      e = VEC[i];
      m3 = i[0];
      wp_ni = e[9];
      c0 = n_cmd;
      frame_start(m3);
      send_bits({e[17:10], ADDR, 8'h5C}, int'(e[8:3]));
      frame_end(m3);
      chk(n_cmd - c0 == int'(e[2]), "R8 R9 issue count", n_cmd - c0, e[2]);
      if (e[2]) begin
        chk(last_cls == e[1:0] && last_op == e[17:10], "R3 class/opcode", {last_cls, last_op}, e[1:0]);
        if (e[1:0] == 2'd1)
          chk(last_page == ADDR[23:10] && last_off == ADDR[9:0], "R4 program address", {last_page, last_off}, ADDR);
      end
    end
    wp_ni = 1'b1;

    // R1: activity with select high
    c0 = n_cmd;
    send_bits({8'h3D, 32'h0}, 16);
    half();
    chk(n_cmd == c0 && io_oe_o == 4'b0000, "R1 deselected ignored", n_cmd - c0, 0);

    // R5 R6 R2: reads
    rd_test(8'h03, 1'b0, 1, 8'hA5, 4'b0010, "R5 single");
    rd_test(8'h3B, 1'b1, 2, 8'h3C, 4'b0011, "R6 dual");
    qe_i = 1'b1;
    rd_test(8'h6B, 1'b0, 4, 8'h96, 4'b1111, "R6 quad");
    rd_test(8'h6B, 1'b1, 4, 8'h17, 4'b1111, "R6 quad mode3");

    // R7: quad without enable
    qe_i = 1'b0;
    c0 = n_cmd;
    frame_start(1'b0);
    send_bits({8'h6B, ADDR, 8'h00}, 32);
    bit_io(1'b0, io, oe);
    chk(oe == 4'b0000, "R7 no lanes driven", oe, 0);
    frame_end(1'b0);
    chk(n_cmd == c0, "R7 no command", n_cmd - c0, 0);

    // R12: status read
    src = 8'hC9;
    c0 = n_cmd;
    frame_start(1'b1);
    send_bits({8'hD7, 32'h0}, 8);
    half();
    chk(n_cmd == c0 + 1 && last_cls == 2'd3 && last_op == 8'hD7, "R12 status issued", last_op, 8'hD7);
    begin
      logic [7:0] got;
      got = '0;
      for (int s = 0; s < 8; s++) begin
        bit_io(1'b0, io, oe);
        got = {got[6:0], io[1]};
      end
      chk(got == 8'hC9 && oe == 4'b0010, "R12 status byte", got, 8'hC9);
    end
    frame_end(1'b1);

    // R11: completion toggle
    busy_i = 1'b1;
    c0 = n_cmd;
    frame_start(1'b0);
    send_bits({8'h25, 32'h0}, 8);
    half();
    chk(n_cmd == c0 + 1 && last_cls == 2'd3, "R11 arm issued", last_cls, 3);
    chk(io_oe_o == 4'b0010 && io_o[1] == 1'b0, "R11 armed level", {io_oe_o, io_o}, 8'h20);
    half(); half();
    chk(io_o[1] == 1'b0, "R11 steady while busy", io_o[1], 0);
    busy_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(io_o[1] == 1'b1 && io_oe_o == 4'b0010, "R11 toggled at done", io_o[1], 1);
    frame_end(1'b0);
    chk(io_oe_o == 4'b0000, "R1 hiz after arm", io_oe_o, 0);

    // R10: reset mid program frame, no restart until next select
    c0 = n_cmd;
    frame_start(1'b0);
    send_bits({8'h02, ADDR, 8'h00}, 24);
    dev_rst_ni = 1'b0; half(); dev_rst_ni = 1'b1; half();
    send_bits({ADDR[7:0], 32'h0}, 8);
    frame_end(1'b0);
    chk(n_cmd == c0, "R10 aborted program dropped", n_cmd - c0, 0);

    // R10: reset during single read stops driving
    src = 8'h40;
    frame_start(1'b0);
    send_bits({8'h03, ADDR, 8'h00}, 32);
    bit_io(1'b0, io, oe);
    dev_rst_ni = 1'b0; half();
    chk(io_oe_o == 4'b0000, "R10 single read aborted", io_oe_o, 0);
    dev_rst_ni = 1'b1;
    bit_io(1'b0, io, oe);
    chk(oe == 4'b0000, "R10 stays idle", oe, 0);
    frame_end(1'b0);

    // R10: reset pin ignored during quad read
    qe_i = 1'b1;
    src = 8'h5A;
    frame_start(1'b0);
    send_bits({8'h6B, ADDR, 8'h00}, 32);
    bit_io(1'b0, io, oe);
    dev_rst_ni = 1'b0; half();
    chk(io_oe_o == 4'b1111, "R10 quad ignores reset pin", io_oe_o, 4'hF);
    begin
      logic [3:0] io2;
      bit_io(1'b0, io2, oe);
      chk({io, io2} == 8'h5A, "R10 quad data intact", {io, io2}, 8'h5A);
    end
    dev_rst_ni = 1'b1;
    frame_end(1'b0);
    qe_i = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule